// File: doc/BRIEF.md
# Received PAUSE Frame Flow Controller

This block serves one port of a gigabit Ethernet MAC. It watches the receive byte stream, which carries start-of-frame, end-of-frame and error markers. It picks out MAC control frames that ask the local station to pause. Such a frame is accepted only once its last byte has arrived without error. The block then checks the frame's length, addressing, type and opcode. After acceptance it holds the local transmitter off for the requested number of pause quanta.

The pause reaches the transmitter as a level inhibit. The transmitter samples this inhibit only between frames, so a frame already on the wire always finishes. While the transmitter reports busy, the pause countdown is frozen, and the full pause time runs only once the line is idle. The response ignores any receive filter that decides whether the PAUSE frame is forwarded. It depends only on the flow-control enable bit and the frame content.

Top module: `rx_pause_ctrl`

## Requirements
- R1: During and right after reset, `tx_inhibit_o` and `pause_active_o` are low.
- R2: A frame is accepted only if its first six bytes, the destination, equal 01-80-C2-00-00-01 or `station_addr_i`. The first byte on the wire is compared with `station_addr_i[47:40]`. Any other destination leaves the outputs untouched.
- R3: Bytes 12–13 must be 0x88, 0x08 (type) and bytes 14–15 must be 0x00, 0x01 (opcode). Byte 0 is the byte sent with `rx_sof_i`. Any other value rejects the frame.
- R4: Bytes 16–17 hold the pause length in quanta, most significant byte first. Let k be the clock edge that samples the last byte of an accepted frame with N > 0. Then `tx_inhibit_o` rises after edge k+1 and stays high for exactly N×QUANTUM_CYCLES cycles while `tx_busy_i` is low.
- R5: A frame whose last byte is sampled while `rx_fc_en_i` is low has no effect.
- R6: A frame ending with `rx_err_i` high on its last byte is discarded, as is a frame shorter than MIN_FRAME_BYTES. A discarded frame leaves a running pause unchanged.
- R7: An accepted frame that arrives during a pause reloads the remaining time with its own length, counted from its own load edge.
- R8: An accepted frame with length 0 drops `tx_inhibit_o` after its load edge, ending any pause.
- R9: While `tx_busy_i` is high, the countdown is frozen and `tx_inhibit_o` holds its value.
- R10: `pause_active_o` is high exactly when a pause is pending and `tx_busy_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | Marks first byte of a frame |
| rx_eof_i | input | 1 | Marks last byte of a frame |
| rx_err_i | input | 1 | Error or bad CRC, qualified with last byte |
| rx_data_i | input | 8 | Receive byte |
| rx_fc_en_i | input | 1 | Receive flow-control enable |
| station_addr_i | input | 48 | Programmed station address, first wire byte in [47:40] |
| tx_busy_i | input | 1 | Transmitter is sending a frame |
| tx_inhibit_o | output | 1 | Hold off new transmit frames |
| pause_active_o | output | 1 | Pause countdown is running |

## Verification
The bench builds the block with QUANTUM_CYCLES = 4 and MIN_FRAME_BYTES = 24. Short quanta keep a 258-quantum pause to about a thousand cycles, so the byte order of the length field can be checked by timing alone. The short minimum length lets two frames arrive back to back inside a running pause. This brings reload, zero-length cancel and discarded-frame cases within reach at exact cycle counts. Frozen countdown under a long busy window is also covered.

// File: rtl/rx_pause_pkg.sv
package rx_pause_pkg;
  localparam logic [47:0] CTRL_MC_ADDR = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETYPE   = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
  localparam int unsigned ADDR_BYTES   = 6;
  localparam int unsigned OFS_TYPE_HI  = 12;
  localparam int unsigned OFS_TYPE_LO  = 13;
  localparam int unsigned OFS_OPC_HI   = 14;
  localparam int unsigned OFS_OPC_LO   = 15;
  localparam int unsigned OFS_PT_HI    = 16;
  localparam int unsigned OFS_PT_LO    = 17;
  localparam int unsigned QUANTA_W     = 16;

  typedef struct packed {
    logic                valid;
    logic [QUANTA_W-1:0] quanta;
  } pause_req_t;
endpackage

// File: rtl/rx_pause_parser.sv
module rx_pause_parser
  import rx_pause_pkg::*;
#(
  parameter int unsigned MIN_FRAME_BYTES = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic        rx_err_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_fc_en_i,
  input  logic [47:0] station_addr_i,
  output pause_req_t  req_o
);
  localparam int unsigned CNT_RAW = $clog2(MIN_FRAME_BYTES + 1);
  localparam int unsigned CNT_W   = (CNT_RAW > 5) ? CNT_RAW : 5;
  localparam logic [CNT_W-1:0] IDX_ADDR_END = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] IDX_T_HI = CNT_W'(OFS_TYPE_HI);
  localparam logic [CNT_W-1:0] IDX_T_LO = CNT_W'(OFS_TYPE_LO);
  localparam logic [CNT_W-1:0] IDX_O_HI = CNT_W'(OFS_OPC_HI);
  localparam logic [CNT_W-1:0] IDX_O_LO = CNT_W'(OFS_OPC_LO);
  localparam logic [CNT_W-1:0] IDX_P_HI = CNT_W'(OFS_PT_HI);
  localparam logic [CNT_W-1:0] IDX_P_LO = CNT_W'(OFS_PT_LO);
  localparam logic [CNT_W:0]   LEN_MIN  = (CNT_W+1)'(MIN_FRAME_BYTES);

  function automatic logic [7:0] addr_byte(input logic [47:0] a,
                                           input logic [CNT_W-1:0] k);
    logic [7:0] b;
    b = 8'h00;
    for (int i = 0; i < int'(ADDR_BYTES); i++) begin
      if (k == CNT_W'(i)) b = a[47-8*i -: 8];
    end
    return b;
  endfunction

  logic                in_frame_q;
  logic [CNT_W-1:0]    cnt_q, cnt_n, idx;
  logic                mc_ok_q, st_ok_q, hdr_ok_q;
  logic                mc_ok_n, st_ok_n, hdr_ok_n;
  logic                mc_hit, st_hit, hdr_hit;
  logic [QUANTA_W-1:0] pt_q, pt_n;
  logic                take, len_ok, accept;

  assign take = rx_valid_i && (rx_sof_i || in_frame_q);
  assign idx  = rx_sof_i ? '0 : cnt_q;

  always_comb begin
    mc_hit = 1'b1;
    st_hit = 1'b1;
    if (idx < IDX_ADDR_END) begin
      mc_hit = (rx_data_i == addr_byte(CTRL_MC_ADDR, idx));
      st_hit = (rx_data_i == addr_byte(station_addr_i, idx));
    end
    unique case (idx)
      IDX_T_HI: hdr_hit = (rx_data_i == CTRL_ETYPE[15:8]);
      IDX_T_LO: hdr_hit = (rx_data_i == CTRL_ETYPE[7:0]);
      IDX_O_HI: hdr_hit = (rx_data_i == PAUSE_OPCODE[15:8]);
      IDX_O_LO: hdr_hit = (rx_data_i == PAUSE_OPCODE[7:0]);
      default:  hdr_hit = 1'b1;
    endcase
  end

  always_comb begin
    mc_ok_n  = (rx_sof_i ? 1'b1 : mc_ok_q)  && mc_hit;
    st_ok_n  = (rx_sof_i ? 1'b1 : st_ok_q)  && st_hit;
    hdr_ok_n = (rx_sof_i ? 1'b1 : hdr_ok_q) && hdr_hit;
    pt_n = pt_q;
    if (idx == IDX_P_HI) pt_n = {rx_data_i, pt_q[7:0]};
    if (idx == IDX_P_LO) pt_n = {pt_q[15:8], rx_data_i};
    cnt_n  = ({1'b0, idx} < LEN_MIN) ? idx + CNT_W'(1) : idx;
    len_ok = ({1'b0, idx} + (CNT_W+1)'(1)) >= LEN_MIN;
    accept = take && rx_eof_i && !rx_err_i && rx_fc_en_i && len_ok &&
             (mc_ok_n || st_ok_n) && hdr_ok_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      mc_ok_q    <= 1'b0;
      st_ok_q    <= 1'b0;
      hdr_ok_q   <= 1'b0;
      pt_q       <= '0;
      req_o      <= '0;
    end else begin
      req_o.valid <= accept;
      if (accept) req_o.quanta <= pt_n;
      if (take) begin
        in_frame_q <= !rx_eof_i;
        cnt_q      <= cnt_n;
        mc_ok_q    <= mc_ok_n;
        st_ok_q    <= st_ok_n;
        hdr_ok_q   <= hdr_ok_n;
        pt_q       <= pt_n;
      end
    end
  end

  AST_REQ_NEEDS_FC_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o.valid |-> $past(rx_fc_en_i)); // R5
  AST_REQ_NEEDS_CLEAN_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o.valid |-> $past(rx_valid_i && rx_eof_i && !rx_err_i)); // R6
endmodule

// File: rtl/rx_pause_timer.sv
module rx_pause_timer
  import rx_pause_pkg::*;
#(
  parameter int unsigned QUANTUM_CYCLES = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [QUANTA_W-1:0] quanta_i,
  input  logic                tx_busy_i,
  output logic                tx_inhibit_o,
  output logic                pause_active_o
);
  localparam int unsigned SUB_RAW = $clog2(QUANTUM_CYCLES);
  localparam int unsigned SUB_W   = (SUB_RAW > 0) ? SUB_RAW : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(QUANTUM_CYCLES - 1);

  logic [QUANTA_W-1:0] rem_q;
  logic [SUB_W-1:0]    sub_q;
  logic                pending;

  assign pending = (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      sub_q <= '0;
    end else if (load_i) begin
      rem_q <= quanta_i;
      sub_q <= '0;
    end else if (pending && !tx_busy_i) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        rem_q <= rem_q - QUANTA_W'(1);
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign tx_inhibit_o   = pending;
  assign pause_active_o = pending && !tx_busy_i;

  AST_FREEZE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_i && !load_i) |=> ($stable(rem_q) && $stable(sub_q))); // R9
  AST_LOAD_TAKES_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rem_q == $past(quanta_i))); // R7
  AST_ZERO_ENDS_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && quanta_i == '0) |=> !tx_inhibit_o); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !pending) |=> !pending); // R4
endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
  import rx_pause_pkg::*;
#(
  parameter int unsigned QUANTUM_CYCLES  = 64,
  parameter int unsigned MIN_FRAME_BYTES = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic        rx_err_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_fc_en_i,
  input  logic [47:0] station_addr_i,
  input  logic        tx_busy_i,
  output logic        tx_inhibit_o,
  output logic        pause_active_o
);
  pause_req_t req;

  rx_pause_parser #(.MIN_FRAME_BYTES(MIN_FRAME_BYTES)) u_parser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i), .rx_eof_i(rx_eof_i),
    .rx_err_i(rx_err_i), .rx_data_i(rx_data_i), .rx_fc_en_i(rx_fc_en_i),
    .station_addr_i(station_addr_i), .req_o(req)
  );

  rx_pause_timer #(.QUANTUM_CYCLES(QUANTUM_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(req.valid), .quanta_i(req.quanta), .tx_busy_i(tx_busy_i),
    .tx_inhibit_o(tx_inhibit_o), .pause_active_o(pause_active_o)
  );
endmodule

// File: tb/tb_rx_pause_ctrl.sv
module tb_rx_pause_ctrl;
  localparam int CLK_PERIOD = 8;
  localparam int QC = 4;
  localparam int MINB = 24;
  localparam logic [47:0] MC = 48'h0180C2000001;
  localparam logic [47:0] STA = 48'h021122334455;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0, fc_en = 1, busy = 0;
  logic [7:0] rx_data = '0;
  logic inhibit, active;

  int checks = 0, fails = 0, run = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pause_ctrl #(.QUANTUM_CYCLES(QC), .MIN_FRAME_BYTES(MINB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_err_i(rx_err), .rx_data_i(rx_data),
    .rx_fc_en_i(fc_en), .station_addr_i(STA), .tx_busy_i(busy),
    .tx_inhibit_o(inhibit), .pause_active_o(active));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [47:0] da, input logic [15:0] et,
                                       input logic [15:0] op, input logic [15:0] pt, input int i);
    if (i < 6) return da[47-8*i -: 8];
    if (i < 12) return 8'hA0 + 8'(i);
    case (i)
      12: return et[15:8];
      13: return et[7:0];
      14: return op[15:8];
      15: return op[7:0];
      16: return pt[15:8];
      17: return pt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // driver: pushes expected inhibit length (cycles) when a pause is expected
  task automatic send(input logic [47:0] da, input logic [15:0] et, input logic [15:0] op,
                      input logic [15:0] pt, input int len, input logic err,
                      input int exp_cycles, input string tag);
    if (exp_cycles > 0) begin
      exp_q.push_back(exp_cycles);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < len; i++) begin
      rx_valid = 1;
      rx_sof = (i == 0);
      rx_eof = (i == len - 1);
      rx_err = err && (i == len - 1);
      rx_data = fbyte(da, et, op, pt, i);
      @(negedge clk);
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; rx_data = '0;
  endtask

  task automatic idle_quiet(input int n, input string tag);
    repeat (n) @(negedge clk);
    check(inhibit == 1'b0, tag, int'(inhibit), 0);
  endtask

  // monitor: measures each inhibit pulse and compares with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (inhibit) run++;
        else if (run > 0) begin
          if (exp_q.size() == 0) check(1'b0, "unexpected pause", run, 0);
          else begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(run == e, t, run, e);
          end
          run = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(inhibit == 0 && active == 0, "R1 in reset", int'({inhibit, active}), 0);
    rst_n = 1;
    @(negedge clk);
    check(inhibit == 0 && active == 0, "R1 after reset", int'({inhibit, active}), 0);

    send(MC, 16'h8808, 16'h0001, 16'd3, MINB, 0, 3*QC, "R2 R4 multicast da");
    idle_quiet(20, "R4 pause over");
    send(STA, 16'h8808, 16'h0001, 16'd5, MINB, 0, 5*QC, "R2 station da");
    idle_quiet(30, "R2 station pause over");
    send(STA ^ 48'h000000000100, 16'h8808, 16'h0001, 16'd5, MINB, 0, 0, "");
    idle_quiet(8, "R2 foreign da ignored");
    send(MC, 16'h8809, 16'h0001, 16'd5, MINB, 0, 0, "");
    idle_quiet(8, "R3 wrong type ignored");
    send(MC, 16'h8808, 16'h0002, 16'd5, MINB, 0, 0, "");
    idle_quiet(8, "R3 wrong opcode ignored");
    fc_en = 0;
    send(MC, 16'h8808, 16'h0001, 16'd5, MINB, 0, 0, "");
    idle_quiet(8, "R5 disabled ignored");
    fc_en = 1;
    send(MC, 16'h8808, 16'h0001, 16'd5, MINB, 1, 0, "");
    idle_quiet(8, "R6 error frame ignored");
    send(MC, 16'h8808, 16'h0001, 16'd5, MINB - 4, 0, 0, "");
    idle_quiet(8, "R6 short frame ignored");

    send(MC, 16'h8808, 16'h0001, 16'h0102, MINB, 0, 258*QC, "R4 msb first length");
    idle_quiet(258*QC + 4, "R4 long pause over");

    send(MC, 16'h8808, 16'h0001, 16'd20, MINB, 0, MINB + 2*QC, "R7 reload");
    send(MC, 16'h8808, 16'h0001, 16'd2, MINB, 0, 0, "");
    idle_quiet(40, "R7 reload over");

    send(MC, 16'h8808, 16'h0001, 16'd20, MINB, 0, MINB, "R8 zero ends pause");
    send(MC, 16'h8808, 16'h0001, 16'd0, MINB, 0, 0, "");
    idle_quiet(4, "R8 zero ends pause");

    send(MC, 16'h8808, 16'h0001, 16'd10, MINB, 0, 10*QC, "R6 discard keeps timer");
    send(MC, 16'h8808, 16'h0001, 16'd1, MINB, 1, 0, "");
    idle_quiet(30, "R6 discard over");

    busy = 1;
    send(MC, 16'h8808, 16'h0001, 16'd3, MINB, 0, 3*QC + 10 - 1, "R9 busy freezes countdown");
    repeat (4) @(negedge clk);
    check(inhibit == 1 && active == 0, "R9 R10 held while busy", int'({inhibit, active}), 2);
    repeat (6) @(negedge clk);
    busy = 0;
    @(negedge clk);
    check(active == 1, "R10 active once idle", int'(active), 1);
    idle_quiet(20, "R9 busy pause over");

    check(exp_q.size() == 0, "all pauses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule